// File: doc/BRIEF.md
# I2C Serial Channel with Address Wake-Up

This block is a byte-oriented serial channel for a two-wire bus. It samples the bus clock and data lines through a synchronizer and recognises start and stop conditions. It shifts frames in and out with the most significant bit first. It can acknowledge a received byte on the ninth clock and records an acknowledge it sees on the bus. The block drives the lines only by pulling them low, so both outputs are pull-low enables for open-drain pads.

The channel raises a one-cycle interrupt when a frame completes. Software chooses whether this happens on the eighth or the ninth rising clock edge. With the wake-up option set, the interrupt is limited to two cases: the first frame after a start carries an address equal to the programmed slave address, or a stop condition appears on the bus. This lets a sleeping host ignore traffic for other devices. As a slave, the channel can stretch the clock after an interrupt, which holds the bus until software releases it. Writing a byte while the channel is enabled starts a transmission.

Top module: `i2c_wake_chan`

## Requirements
- R1: After reset, `start_flag`, `stop_flag`, `ack_flag`, `irq`, `scl_drive_low`, `sda_drive_low` and `rx_data` are all 0.
- R2: A falling data line while the clock line is high sets `start_flag`. A rising data line while the clock line is high sets `stop_flag` and clears `start_flag`.
- R3: The three flags stay set until their own clear input (`clr_start`, `clr_stop`, `clr_ack`) is pulsed. A clear pulse in the same cycle as a new detection of that flag is ignored.
- R4: Bits sampled on successive clock rising edges after a start are shifted into `rx_data` MSB first. After eight edges, `rx_data` holds the byte as it was sent.
- R5: With `ack_en` high and no transmission in progress, `sda_drive_low` goes to 1 from the clock fall after the 8th rising edge until the clock fall after the 9th. With `ack_en` low it stays 0.
- R6: A low data line at the 9th rising edge sets `ack_flag`. A high data line leaves it clear.
- R7: With `wake_en` low, `irq` pulses once per frame: on the 8th rising edge when `irq_ninth`=0, and on the 9th when `irq_ninth`=1.
- R8: With `wake_en` high, the frame interrupt fires only for the first frame after a start whose upper seven bits (bit 7 down to bit 1; bit 0 is the read/write bit) equal `slave_addr`. Later data frames never interrupt. A stop condition also pulses `irq`.
- R9: With `wait_en` high, `scl_drive_low` goes to 1 at the first clock fall after a frame interrupt. It holds the clock low, so no further bits are received, until `rel_wait` or `tx_load` is pulsed.
- R10: A `tx_load` pulse while `en`=1 loads `tx_data`. The block then pulls the data line low for each 0 bit, MSB first, changing it only while the clock is low, and releases the line for the 9th clock. A `tx_load` while `en`=0 has no effect.
- R11: A start condition in the middle of a frame resets the bit count, so the next eight bits are treated as an address.
- R12: While `en`=0, `irq`, `scl_drive_low` and `sda_drive_low` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| ack_en | input | 1 | Drive an acknowledge after each received byte |
| irq_ninth | input | 1 | 0: interrupt on 8th rising edge, 1: on 9th |
| wake_en | input | 1 | Wake-up filtering of the interrupt |
| wait_en | input | 1 | Stretch the clock after a frame interrupt |
| slave_addr | input | ADDR_W | Own 7-bit slave address |
| tx_load | input | 1 | Pulse: load `tx_data` and start sending |
| tx_data | input | DATA_W | Byte to transmit |
| rel_wait | input | 1 | Pulse: release a clock stretch |
| clr_start | input | 1 | Pulse: clear `start_flag` |
| clr_stop | input | 1 | Pulse: clear `stop_flag` |
| clr_ack | input | 1 | Pulse: clear `ack_flag` |
| scl_drive_low | output | 1 | Pull the clock line low |
| sda_drive_low | output | 1 | Pull the data line low |
| rx_data | output | DATA_W | Shift register contents / received byte |
| irq | output | 1 | One-cycle transfer interrupt |
| start_flag | output | 1 | Sticky start-detected flag |
| stop_flag | output | 1 | Sticky stop-detected flag |
| ack_flag | output | 1 | Sticky acknowledge-detected flag |

## Verification
The bench sends a restart three bits into a frame, followed by the channel's own address. A counter that is not reset would close the frame early and miss the match. It sends a matching byte as a data frame after the address, where a design that did not gate on the first frame would interrupt a second time. It raises a clear pulse in the exact cycle a stop is detected, which would wrongly leave the flag clear if the clear had priority. It tries to clock during a clock stretch, where a channel that did not hold the line would keep shifting. In both interrupt-point settings it counts interrupts before and after the ninth clock, so an interrupt on the wrong edge shows up as a count that is off by one.

// File: rtl/i2c_wk_pkg.sv
package i2c_wk_pkg;
   // bus events derived from the synchronized lines
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_ev_t;
endpackage

// File: rtl/i2c_wk_sync.sv
module i2c_wk_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;   // idle bus lines are high
         else        ff <= {ff[STAGES-2:0], d[i]};
      end
      assign q[i] = ff[STAGES-1];
   end
endmodule

// File: rtl/i2c_wk_cond.sv
module i2c_wk_cond
   import i2c_wk_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_s,
   input  logic    sda_s,
   output bus_ev_t ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      ev.start = scl_s & scl_p & sda_p & ~sda_s;
      ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
      ev.rise  = scl_s & ~scl_p;
      ev.fall  = ~scl_s & scl_p;
      ev.sda   = sda_s;
   end
endmodule

// File: rtl/i2c_wk_shift.sv
module i2c_wk_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ack_en,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              ev_start,
   input  logic              ev_rise,
   input  logic              ev_fall,
   input  logic              sda_s,
   output logic [DATA_W-1:0] rx_data,
   output logic              sda_drive_low,
   output logic              byte_edge,
   output logic              ack_edge,
   output logic              first_frame
);
   localparam int             CW   = $clog2(DATA_W + 1);
   localparam logic [CW-1:0]  LAST = CW'(DATA_W);
   localparam logic [CW-1:0]  PRE  = CW'(DATA_W - 1);

   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] shreg;
   logic              out_bit, tx_act, ack_drv, first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         shreg   <= '0;
         out_bit <= 1'b1;
         tx_act  <= 1'b0;
         ack_drv <= 1'b0;
         first   <= 1'b0;
      end else if (!en) begin
         cnt     <= '0;
         tx_act  <= 1'b0;
         ack_drv <= 1'b0;
         first   <= 1'b0;
      end else begin
         if (ev_start) begin
            // start or restart: next frame is an address
            cnt     <= '0;
            first   <= 1'b1;
            ack_drv <= 1'b0;
         end else if (ev_rise) begin
            if (cnt == LAST) begin
               cnt   <= '0;
               first <= 1'b0;
            end else begin
               cnt   <= cnt + 1'b1;
               shreg <= {shreg[DATA_W-2:0], sda_s};
            end
         end else if (ev_fall) begin
            out_bit <= shreg[DATA_W-1];
            if (cnt == LAST) begin
               tx_act  <= 1'b0;
               ack_drv <= ack_en & ~tx_act;
            end else if (cnt == '0) begin
               ack_drv <= 1'b0;
            end
         end
         if (tx_load) begin
            shreg   <= tx_data;
            out_bit <= tx_data[DATA_W-1];
            tx_act  <= 1'b1;
         end
      end
   end

   assign rx_data       = shreg;
   assign sda_drive_low = (tx_act & ~out_bit) | ack_drv;
   assign byte_edge     = en & ev_rise & (cnt == PRE);
   assign ack_edge      = en & ev_rise & (cnt == LAST);
   assign first_frame   = first;
endmodule

// File: rtl/i2c_wk_ctl.sv
module i2c_wk_ctl #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              irq_ninth,
   input  logic              wake_en,
   input  logic              wait_en,
   input  logic [ADDR_W-1:0] slave_addr,
   input  logic              rel_wait,
   input  logic              tx_load,
   input  logic              clr_start,
   input  logic              clr_stop,
   input  logic              clr_ack,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_fall,
   input  logic              sda_s,
   input  logic              byte_edge,
   input  logic              ack_edge,
   input  logic              first_frame,
   input  logic [ADDR_W-1:0] addr_now,
   output logic              irq,
   output logic              scl_drive_low,
   output logic              start_flag,
   output logic              stop_flag,
   output logic              ack_flag
);
   logic addr_hit, wait_pend;
   logic hit_now, irq_pt, match_ok, frame_irq;

   always_comb begin
      hit_now   = (addr_now == slave_addr);
      irq_pt    = irq_ninth ? ack_edge : byte_edge;
      match_ok  = irq_ninth ? addr_hit : hit_now;
      frame_irq = irq_pt & (~wake_en | (first_frame & match_ok));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq           <= 1'b0;
         addr_hit      <= 1'b0;
         wait_pend     <= 1'b0;
         scl_drive_low <= 1'b0;
      end else begin
         irq <= en & (frame_irq | (wake_en & ev_stop));
         if (byte_edge) addr_hit <= first_frame & hit_now;
         if (!en || tx_load || rel_wait) begin
            wait_pend     <= 1'b0;
            scl_drive_low <= 1'b0;
         end else if (frame_irq && wait_en) begin
            wait_pend <= 1'b1;
         end else if (wait_pend && ev_fall) begin
            wait_pend     <= 1'b0;
            scl_drive_low <= 1'b1;
         end
      end
   end

   // sticky flags: a detection outranks its clear pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_flag <= 1'b0;
         stop_flag  <= 1'b0;
         ack_flag   <= 1'b0;
      end else begin
         if (ev_start)                  start_flag <= 1'b1;
         else if (ev_stop || clr_start) start_flag <= 1'b0;
         if (ev_stop)                   stop_flag  <= 1'b1;
         else if (clr_stop)             stop_flag  <= 1'b0;
         if (ack_edge && !sda_s)        ack_flag   <= 1'b1;
         else if (clr_ack)              ack_flag   <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_wake_chan.sv
module i2c_wake_chan #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              ack_en,
   input  logic              irq_ninth,
   input  logic              wake_en,
   input  logic              wait_en,
   input  logic [ADDR_W-1:0] slave_addr,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rel_wait,
   input  logic              clr_start,
   input  logic              clr_stop,
   input  logic              clr_ack,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   output logic [DATA_W-1:0] rx_data,
   output logic              irq,
   output logic              start_flag,
   output logic              stop_flag,
   output logic              ack_flag
);
   import i2c_wk_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("DATA_W must equal ADDR_W + 1");
   end

   logic [1:0] line_s;
   logic       scl_s, sda_s;
   bus_ev_t    ev;
   logic       start_ev, stop_ev;
   logic       byte_edge, ack_edge, first_frame;

   i2c_wk_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s));

   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   i2c_wk_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .ev(ev));

   assign start_ev = ev.start;
   assign stop_ev  = ev.stop;

   i2c_wk_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en), .ack_en(ack_en),
      .tx_load(tx_load), .tx_data(tx_data),
      .ev_start(ev.start), .ev_rise(ev.rise), .ev_fall(ev.fall),
      .sda_s(ev.sda), .rx_data(rx_data), .sda_drive_low(sda_drive_low),
      .byte_edge(byte_edge), .ack_edge(ack_edge), .first_frame(first_frame));

   i2c_wk_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .en(en), .irq_ninth(irq_ninth),
      .wake_en(wake_en), .wait_en(wait_en), .slave_addr(slave_addr),
      .rel_wait(rel_wait), .tx_load(tx_load),
      .clr_start(clr_start), .clr_stop(clr_stop), .clr_ack(clr_ack),
      .ev_start(ev.start), .ev_stop(ev.stop), .ev_fall(ev.fall),
      .sda_s(sda_s), .byte_edge(byte_edge), .ack_edge(ack_edge),
      .first_frame(first_frame), .addr_now(rx_data[ADDR_W-1:0]),
      .irq(irq), .scl_drive_low(scl_drive_low),
      .start_flag(start_flag), .stop_flag(stop_flag), .ack_flag(ack_flag));
endmodule

// File: rtl/i2c_wk_chk.sv
module i2c_wk_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic tx_load,
   input logic rel_wait,
   input logic scl_s,
   input logic start_ev,
   input logic stop_ev,
   input logic irq,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic start_flag,
   input logic stop_flag
);
   AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> start_flag);                                         // R3
   AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (stop_flag && !start_flag));                          // R2
   AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);                                                    // R7
   AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_ev) && !$past(tx_load) && $past(en))
         |-> $stable(sda_drive_low));                                   // R10
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!irq && !scl_drive_low && !sda_drive_low));              // R12
   AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rel_wait |=> !scl_drive_low);                                     // R9
endmodule

bind i2c_wake_chan i2c_wk_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .tx_load(tx_load), .rel_wait(rel_wait),
   .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev), .irq(irq),
   .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
   .start_flag(start_flag), .stop_flag(stop_flag));

// File: tb/i2c_wake_chan_test.sv
`timescale 1ns/1ps
module i2c_wake_chan_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b1, ack_en = 1'b0, irq_ninth = 1'b0, wake_en = 1'b0, wait_en = 1'b0;
   logic [6:0] slave_addr = 7'h2A;
   logic       tx_load = 1'b0, rel_wait = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       clr_start = 1'b0, clr_stop = 1'b0, clr_ack = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       scl_drive_low, sda_drive_low, irq, start_flag, stop_flag, ack_flag;
   logic [7:0] rx_data;
   logic       scl_bus, sda_bus;
   int         checks = 0, fails = 0, irq_total = 0;

   always #5 clk = ~clk;

   assign scl_bus = scl_m & ~scl_drive_low;
   assign sda_bus = sda_m & ~sda_drive_low;

   i2c_wake_chan uut (
      .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_bus), .sda_in(sda_bus),
      .ack_en(ack_en), .irq_ninth(irq_ninth), .wake_en(wake_en), .wait_en(wait_en),
      .slave_addr(slave_addr), .tx_load(tx_load), .tx_data(tx_data),
      .rel_wait(rel_wait), .clr_start(clr_start), .clr_stop(clr_stop), .clr_ack(clr_ack),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .rx_data(rx_data),
      .irq(irq), .start_flag(start_flag), .stop_flag(stop_flag), .ack_flag(ack_flag));

   always @(negedge clk) if (irq) irq_total++;

   // fields: [12:5] byte, [4] ninth, [3] wake, [2] ack_en, [1] irqs after 8, [0] irqs after 9
   localparam logic [12:0] VEC [6] = '{
      {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      {8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'h55, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      {8'h56, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h54, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
   };

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wclk(4);
      scl_m = 1'b1; wclk(4);
      sda_m = 1'b0; wclk(4);
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wclk(4);
      scl_m = 1'b1; wclk(4);
      sda_m = 1'b1; wclk(4);
   endtask

   task automatic send_bit(input logic b, output logic seen);
      sda_m = b;    wclk(4);
      scl_m = 1'b1; wclk(4);
      seen  = sda_bus;
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) send_bit(b[i], s);
   endtask

   task automatic clear_flags();
      clr_start = 1'b1; clr_stop = 1'b1; clr_ack = 1'b1; wclk(1);
      clr_start = 1'b0; clr_stop = 1'b0; clr_ack = 1'b0; wclk(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic s;
      int   base;
      logic [7:0] got;
      wclk(3); rst_n = 1'b1; wclk(3);

      // R1 reset state
      chk("R1 flags", 32'({start_flag, stop_flag, ack_flag}), 32'h0);
      chk("R1 drives", 32'({scl_drive_low, sda_drive_low, irq}), 32'h0);
      chk("R1 rx_data", 32'(rx_data), 32'h0);

      // vector walk: R2 R4 R5 R6 R7 R8
      for (int i = 0; i < 6; i++) begin
         logic [12:0] v;
         v = VEC[i];
         irq_ninth = v[4]; wake_en = v[3]; ack_en = v[2];
         clear_flags();
         base = irq_total;
         bus_start();
         chk("R2 start sets flag", 32'(start_flag), 32'h1);
         send_byte(v[12:5]);
         chk("R7/R8 irqs after 8th edge", 32'(irq_total - base), 32'(v[1]));
         chk("R4 received byte", 32'(rx_data), 32'(v[12:5]));
         chk("R5 ack drive in 9th slot", 32'(sda_drive_low), 32'(v[2]));
         send_bit(1'b1, s);
         chk("R5 bus data at 9th edge", 32'(s), 32'(!v[2]));
         chk("R7/R8 irqs after 9th edge", 32'(irq_total - base), 32'(v[0]));
         chk("R6 ack flag", 32'(ack_flag), 32'(v[2]));
         chk("R5 ack released", 32'(sda_drive_low), 32'h0);
         bus_stop();
         chk("R2 stop sets flag", 32'(stop_flag), 32'h1);
         chk("R2 stop clears start flag", 32'(start_flag), 32'h0);
         chk("R8 stop irq in wake mode", 32'(irq_total - base), 32'(v[0]) + 32'(v[3]));
      end
      wake_en = 1'b0; ack_en = 1'b0; irq_ninth = 1'b0;

      // R3 sticky flag, clear, and clear colliding with detection
      clr_stop = 1'b1; wclk(1); clr_stop = 1'b0; wclk(1);
      chk("R3 clr_stop clears", 32'(stop_flag), 32'h0);
      wclk(2);
      chk("R3 flag stays clear", 32'(stop_flag), 32'h0);
      bus_start();
      sda_m = 1'b0; wclk(4);
      scl_m = 1'b1; wclk(4);
      sda_m = 1'b1;          // stop seen by the core two edges later
      wclk(1);
      wclk(1); clr_stop = 1'b1;
      wclk(1); clr_stop = 1'b0;
      wclk(2);
      chk("R3 clear ignored on detection cycle", 32'(stop_flag), 32'h1);
      clr_stop = 1'b1; wclk(1); clr_stop = 1'b0; wclk(1);
      chk("R3 later clear works", 32'(stop_flag), 32'h0);

      // R9 clock stretch
      wait_en = 1'b1;
      base = irq_total;
      bus_start();
      send_byte(8'h96);
      chk("R9 irq before stretch", 32'(irq_total - base), 32'h1);
      chk("R9 stretch asserted", 32'(scl_drive_low), 32'h1);
      sda_m = 1'b1; wclk(4);
      scl_m = 1'b1; wclk(8);
      chk("R9 clock held low", 32'(scl_bus), 32'h0);
      chk("R9 no progress while held", 32'(rx_data), 32'h96);
      rel_wait = 1'b1; wclk(1); rel_wait = 1'b0; wclk(4);
      chk("R9 stretch released", 32'(scl_drive_low), 32'h0);
      scl_m = 1'b0; wclk(4);
      send_byte(8'h81);
      chk("R9 second frame received", 32'(rx_data), 32'h81);
      chk("R9 second irq", 32'(irq_total - base), 32'h2);
      rel_wait = 1'b1; wclk(1); rel_wait = 1'b0; wclk(2);
      wait_en = 1'b0;
      send_bit(1'b1, s);
      bus_stop();

      // R10 transmit
      clear_flags();
      bus_start();
      tx_data = 8'hB2; tx_load = 1'b1; wclk(1); tx_load = 1'b0; wclk(1);
      got = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         send_bit(1'b1, s);
         got[i] = s;
      end
      chk("R10 transmitted byte on bus", 32'(got), 32'hB2);
      chk("R10 line released for 9th", 32'(sda_drive_low), 32'h0);
      send_bit(1'b0, s);
      chk("R6 ack seen from master", 32'(ack_flag), 32'h1);
      bus_stop();

      // R10 R12 disabled channel
      en = 1'b0; wclk(2);
      tx_data = 8'h00; tx_load = 1'b1; wclk(1); tx_load = 1'b0; wclk(3);
      chk("R10 load ignored while off", 32'(sda_drive_low), 32'h0);
      base = irq_total;
      bus_start();
      send_byte(8'h54);
      send_bit(1'b1, s);
      chk("R12 no irq while off", 32'(irq_total - base), 32'h0);
      chk("R12 no drives while off", 32'({scl_drive_low, sda_drive_low}), 32'h0);
      bus_stop();
      en = 1'b1; wclk(2);

      // R11 restart mid-frame, then R8 data frame gating
      wake_en = 1'b1;
      base = irq_total;
      bus_start();
      send_bit(1'b1, s); send_bit(1'b0, s); send_bit(1'b1, s);
      bus_start();
      send_byte(8'h54);
      chk("R11 address after restart matches", 32'(irq_total - base), 32'h1);
      send_bit(1'b0, s);
      send_byte(8'h54);
      send_bit(1'b0, s);
      chk("R8 data frame does not interrupt", 32'(irq_total - base), 32'h1);
      bus_stop();
      chk("R8 stop interrupts in wake mode", 32'(irq_total - base), 32'h2);
      wake_en = 1'b0;

      wclk(4);
      summary();
   end
endmodule